// File: doc/BRIEF.md
# ADC Serial Result Shifter

This block is the serial output path of a 12-bit converter. It sends one result word, most significant bit first, on a single data line. A mode input selects the source of the data clock. In internal mode the block makes its own data clock from the system clock and drives it out. Each accepted conversion command sends the previous conversion's result. In external mode the data clock is an input. A read command sends one of two words: the newest result when no conversion is running, or the previous result while a conversion is in progress.

Commands come from two active-low-style control lines, a chip-select and a read/convert line. The block treats them as levels. A convert command is both lines low. A read command is chip-select low with read/convert high. Each command acts on its rising (asserting) edge, sampled by the system clock. The external data clock is also sampled by the system clock, so it must be much slower than the system clock. A format input picks straight binary, or two's complement, which flips the sign bit. When nothing is being sent, the data line and the clock output stay low.

Top module: `adc_ser_shifter`

## Requirements
- R1: After reset, `sdata_o` and `dclk_o` are low.
- R2: In internal mode, a convert command (`cs_ni` and `rc_i` both low, newly asserted) while `busy_ni` is high starts a transfer of `prev_word_i`, MSB first. Bit k (k = 0 for the MSB) is on `sdata_o` for the 2*HALF_DIV cycles starting HALF_DIV*2*k cycles after the load edge. `dclk_o` is low for the first HALF_DIV cycles of each bit and high for the last HALF_DIV cycles.
- R3: Once all 12 bits have been sent, `sdata_o` and `dclk_o` return low and stay low.
- R4: A convert command given while `busy_ni` is low starts no transfer.
- R5: In external mode, `dclk_o` stays low, and a convert command starts no transfer.
- R6: In external mode, a read command with `busy_ni` high loads `cur_word_i`. The line stays low until the first rising edge of `ext_clk_i`. Each rising edge then presents the next bit, MSB first. On the 13th rising edge the line returns low.
- R7: In external mode, a read command with `busy_ni` low sends `prev_word_i` instead.
- R8: In internal mode, a read command has no effect on `sdata_o` or `dclk_o`.
- R9: A read command is taken either from `rc_i` rising while `cs_ni` is low, or from `cs_ni` falling while `rc_i` is high.
- R10: With `straight_bin_i` high the word is sent unchanged. With it low, bit 11 is inverted (two's complement form).
- R11: A command that arrives during a transfer abandons it. A new read reloads and restarts. A convert command in external mode clears the line to low on the next cycle.
- R12: Rising edges of `ext_clk_i` with no transfer pending leave `sdata_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | 1: data clock is supplied on ext_clk_i; 0: internal data clock |
| cs_ni | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read (high) / convert (low) |
| busy_ni | input | 1 | Low while a conversion is running |
| ext_clk_i | input | 1 | External data clock, already synchronous to clk_i |
| straight_bin_i | input | 1 | 1: straight binary, 0: two's complement |
| cur_word_i | input | W | Result of the latest completed conversion |
| prev_word_i | input | W | Result of the conversion before it |
| sdata_o | output | 1 | Serial data, MSB first |
| dclk_o | output | 1 | Internal data clock output, low in external mode |

## Verification
Internal-mode transfers are swept over corner words and over a spread of words taken in arithmetic steps, in both formats. Every cycle of the data clock and data line is compared with a position computed from the divider length. External reads are swept over the same words, with both BUSY states and both ways of giving a read. This separates a wrong word choice, a bad format, a wrong start route and an off-by-one in the first or last clock edge. Separate runs give commands during BUSY, read commands in internal mode, convert commands and stray clock edges in external mode, and new commands part way through a transfer. Together they show which stimuli must leave the line untouched.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  // straight binary passes the word through; two's complement flips the sign bit
  function automatic logic [11:0] fmt_word(input logic [11:0] w, input logic straight);
    return straight ? w : {~w[11], w[10:0]};
  endfunction
endpackage

// File: rtl/adc_ser_trig.sv
module adc_ser_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rc_i,
  input  logic busy_ni,
  input  logic ext_mode_i,
  input  logic ext_clk_i,
  output logic conv_start_o,
  output logic read_start_o,
  output logic ext_rise_o
);
  logic conv_lvl, read_lvl;
  logic conv_q, read_q, eclk_q;

  assign conv_lvl = ~cs_ni & ~rc_i;
  assign read_lvl = ~cs_ni & rc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q <= 1'b0;
      read_q <= 1'b0;
      eclk_q <= 1'b0;
    end else begin
      conv_q <= conv_lvl;
      read_q <= read_lvl;
      eclk_q <= ext_clk_i;
    end
  end

  assign conv_start_o = conv_lvl & ~conv_q & busy_ni;
  assign read_start_o = read_lvl & ~read_q & ext_mode_i;
  assign ext_rise_o   = ext_clk_i & ~eclk_q;
endmodule

// File: rtl/adc_ser_clkgen.sv
module adc_ser_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o,
  output logic dclk_o
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HALF = CW'(HALF_DIV);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (cnt_q == LAST)       cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i & ~restart_i & (cnt_q == LAST);
  assign dclk_o = run_i & (cnt_q >= HALF);
endmodule

// File: rtl/adc_ser_shreg.sv
module adc_ser_shreg #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         load_ext_i,
  input  logic [W-1:0] word_i,
  input  logic         adv_i,
  input  logic         abort_i,
  output logic         active_o,
  output logic         sdata_o
);
  localparam int RW = $clog2(W + 2);
  localparam logic [RW-1:0] N_INT = RW'(W);
  localparam logic [RW-1:0] N_EXT = RW'(W + 1);

  logic [W:0]    sh_q;
  logic [RW-1:0] rem_q;
  logic          act_q;

  // external transfers carry a leading idle slot so the MSB waits for the first edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      rem_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      act_q <= 1'b1;
      sh_q  <= load_ext_i ? {1'b0, word_i} : {word_i, 1'b0};
      rem_q <= load_ext_i ? N_EXT : N_INT;
    end else if (abort_i) begin
      act_q <= 1'b0;
      sh_q  <= '0;
      rem_q <= '0;
    end else if (act_q && adv_i) begin
      if (rem_q == RW'(1)) begin
        act_q <= 1'b0;
        sh_q  <= '0;
        rem_q <= '0;
      end else begin
        sh_q  <= {sh_q[W-1:0], 1'b0};
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign active_o = act_q;
  assign sdata_o  = act_q & sh_q[W];
endmodule

// File: rtl/adc_ser_shifter.sv
module adc_ser_shifter #(
  parameter int W        = 12,
  parameter int HALF_DIV = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ext_mode_i,
  input  logic         cs_ni,
  input  logic         rc_i,
  input  logic         busy_ni,
  input  logic         ext_clk_i,
  input  logic         straight_bin_i,
  input  logic [W-1:0] cur_word_i,
  input  logic [W-1:0] prev_word_i,
  output logic         sdata_o,
  output logic         dclk_o
);
  import adc_ser_pkg::*;

  logic conv_start, read_start, ext_rise;
  logic load, abort, active, tick, adv;
  logic [W-1:0] sel_word, fmt_w;

  adc_ser_trig i_trig (
    .clk_i, .rst_ni, .cs_ni, .rc_i, .busy_ni, .ext_mode_i, .ext_clk_i,
    .conv_start_o(conv_start),
    .read_start_o(read_start),
    .ext_rise_o  (ext_rise)
  );

  assign load  = (conv_start & ~ext_mode_i) | read_start;
  assign abort = conv_start & ext_mode_i;

  // internal mode always sends the prior result; external read picks by BUSY
  assign sel_word = (ext_mode_i && busy_ni) ? cur_word_i : prev_word_i;

  generate
    if (W == 12) begin : g_fmt12
      assign fmt_w = fmt_word(sel_word, straight_bin_i);
    end else begin : g_fmtw
      assign fmt_w = straight_bin_i ? sel_word : {~sel_word[W-1], sel_word[W-2:0]};
    end
  endgenerate

  adc_ser_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
    .clk_i, .rst_ni,
    .run_i    (active & ~ext_mode_i),
    .restart_i(load),
    .tick_o   (tick),
    .dclk_o   (dclk_o)
  );

  assign adv = ext_mode_i ? ext_rise : tick;

  adc_ser_shreg #(.W(W)) i_shreg (
    .clk_i, .rst_ni,
    .load_i    (load),
    .load_ext_i(ext_mode_i),
    .word_i    (fmt_w),
    .adv_i     (adv),
    .abort_i   (abort),
    .active_o  (active),
    .sdata_o   (sdata_o)
  );
endmodule

// File: rtl/adc_ser_shifter_chk.sv
module adc_ser_shifter_chk #(
  parameter int W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ext_mode_i,
  input logic         busy_ni,
  input logic         straight_bin_i,
  input logic [W-1:0] prev_word_i,
  input logic         sdata_o,
  input logic         dclk_o,
  input logic         conv_start,
  input logic         read_start,
  input logic         load,
  input logic         active
);
  p_int_msb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start && !ext_mode_i) |=>
      (sdata_o == $past(straight_bin_i ? prev_word_i[W-1] : !prev_word_i[W-1])));

  p_stable_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dclk_o && $past(dclk_o) && !$past(load)) |-> $stable(sdata_o));

  p_conv_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_ni && !ext_mode_i && !active) |=> !active);

  p_dclk_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_mode_i |-> !dclk_o);

  p_first_slot_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_start |=> !sdata_o);

  p_ext_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start && ext_mode_i) |=> (!sdata_o && !active));
endmodule

bind adc_ser_shifter adc_ser_shifter_chk #(.W(W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ext_mode_i    (ext_mode_i),
  .busy_ni       (busy_ni),
  .straight_bin_i(straight_bin_i),
  .prev_word_i   (prev_word_i),
  .sdata_o       (sdata_o),
  .dclk_o        (dclk_o),
  .conv_start    (conv_start),
  .read_start    (read_start),
  .load          (load),
  .active        (active)
);

// File: tb/test_adc_ser_shifter.sv
module test_adc_ser_shifter;
  localparam int  CLK_PERIOD = 10;
  localparam int  W          = 12;
  localparam int  HD         = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_mode_i = 1'b0, cs_ni = 1'b1, rc_i = 1'b1, busy_ni = 1'b1;
  logic ext_clk_i = 1'b0, straight_bin_i = 1'b1;
  logic [W-1:0] cur_word_i = '0, prev_word_i = '0;
  logic sdata_o, dclk_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ser_shifter #(.W(W), .HALF_DIV(HD)) i_adc_ser_shifter (
    .clk_i(clk), .rst_ni, .ext_mode_i, .cs_ni, .rc_i, .busy_ni, .ext_clk_i,
    .straight_bin_i, .cur_word_i, .prev_word_i, .sdata_o, .dclk_o
  );

  function automatic logic [W-1:0] fmt(input logic [W-1:0] w, input logic sb);
    return sb ? w : (w ^ (W'(1) << (W-1)));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // internal-mode conversion; checks every cycle of the transfer (R2, R3, R10)
  task automatic int_xfer(input logic [W-1:0] w, input logic sb);
    logic [W-1:0] e;
    e = fmt(w, sb);
    @(negedge clk);
    prev_word_i = w; straight_bin_i = sb;
    cs_ni = 1'b0; rc_i = 1'b0;
    for (int j = 0; j < 2*HD*W; j++) begin
      @(negedge clk);
      chk("R2 dclk", int'(dclk_o), int'((j % (2*HD)) >= HD));
      chk(sb ? "R2 data" : "R10 data", int'(sdata_o), int'(e[W-1 - j/(2*HD)]));
    end
    @(negedge clk);
    chk("R3 idle data", int'(sdata_o), 0);
    chk("R3 idle dclk", int'(dclk_o), 0);
    cs_ni = 1'b1; rc_i = 1'b1;
  endtask

  task automatic ext_pulse_chk(input string req, input logic exp);
    @(negedge clk); ext_clk_i = 1'b1;
    @(negedge clk);
    chk(req, int'(sdata_o), int'(exp));
    ext_clk_i = 1'b0;
  endtask

  // issues an external read; R9 covers both routes
  task automatic ext_start(input logic via_cs);
    @(negedge clk);
    if (via_cs) begin
      cs_ni = 1'b1; rc_i = 1'b1;
      @(negedge clk); cs_ni = 1'b0;
    end else begin
      cs_ni = 1'b1; rc_i = 1'b0;
      @(negedge clk); cs_ni = 1'b0;
      @(negedge clk); rc_i = 1'b1;
    end
    @(negedge clk);
    chk("R6 first slot low", int'(sdata_o), 0);
  endtask

  task automatic ext_xfer(input logic [W-1:0] cw, input logic [W-1:0] pw,
                          input logic bz, input logic sb, input logic via_cs);
    logic [W-1:0] e;
    cur_word_i = cw; prev_word_i = pw; straight_bin_i = sb; busy_ni = bz;
    e = fmt(bz ? cw : pw, sb);
    ext_start(via_cs);
    for (int b = 0; b < W; b++)
      ext_pulse_chk(via_cs ? (bz ? "R9 R6 bit" : "R9 R7 bit") : (bz ? "R6 bit" : "R7 bit"),
                    e[W-1-b]);
    ext_pulse_chk("R6 end low", 1'b0);
    chk("R5 dclk", int'(dclk_o), 0);
    @(negedge clk); cs_ni = 1'b1; rc_i = 1'b1; busy_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    repeat (3) @(negedge clk);
    chk("R1 data", int'(sdata_o), 0);
    chk("R1 dclk", int'(dclk_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 data after release", int'(sdata_o), 0);

    // internal sweep: corners then arithmetic spread, both formats
    for (int i = 0; i < 20; i++) begin
      case (i)
        0: w = 12'h000; 1: w = 12'hFFF; 2: w = 12'h800; 3: w = 12'h7FF;
        default: w = W'((i * 1103 + 5) % 4096);
      endcase
      int_xfer(w, 1'b1);
      int_xfer(w, 1'b0);
    end

    // R4: convert during BUSY low
    @(negedge clk); busy_ni = 1'b0; prev_word_i = 12'hFFF; straight_bin_i = 1'b1;
    cs_ni = 1'b0; rc_i = 1'b0;
    for (int j = 0; j < 4*HD; j++) begin
      @(negedge clk);
      chk("R4 data", int'(sdata_o), 0);
      chk("R4 dclk", int'(dclk_o), 0);
    end
    cs_ni = 1'b1; rc_i = 1'b1; busy_ni = 1'b1;

    // R8: read command in internal mode
    @(negedge clk); cs_ni = 1'b0;
    for (int j = 0; j < 4*HD; j++) begin
      @(negedge clk);
      chk("R8 data", int'(sdata_o), 0);
      chk("R8 dclk", int'(dclk_o), 0);
    end
    cs_ni = 1'b1;
    int_xfer(12'hA5C, 1'b1);

    // R11: internal restart mid-transfer with a new word
    @(negedge clk); prev_word_i = 12'hFFF; cs_ni = 1'b0; rc_i = 1'b0;
    repeat (3*2*HD) @(negedge clk);
    cs_ni = 1'b1; rc_i = 1'b1;
    @(negedge clk);
    int_xfer(12'h135, 1'b1);

    // external mode
    @(negedge clk); ext_mode_i = 1'b1;
    for (int i = 0; i < 16; i++) begin
      w = W'((i * 2741 + 17) % 4096);
      ext_xfer(w, ~w, 1'b1, 1'(i % 3 != 0), 1'(i % 2));
      ext_xfer(~w, w, 1'b0, 1'(i % 3 == 0), 1'(1 - i % 2));
    end

    // R5 and R12: convert command then stray clock edges
    @(negedge clk); cur_word_i = 12'hFFF; prev_word_i = 12'hFFF;
    cs_ni = 1'b0; rc_i = 1'b0;
    for (int j = 0; j < 4; j++) ext_pulse_chk("R5 R12 no transfer", 1'b0);
    chk("R5 dclk held", int'(dclk_o), 0);
    @(negedge clk); cs_ni = 1'b1; rc_i = 1'b1;

    // R11: new read restarts mid-transfer
    cur_word_i = 12'hF00; busy_ni = 1'b1; straight_bin_i = 1'b1;
    ext_start(1'b1);
    for (int b = 0; b < 4; b++) ext_pulse_chk("R11 first word", 1'(b < 4));
    cur_word_i = 12'h0F3;
    ext_start(1'b1);
    for (int b = 0; b < W; b++) ext_pulse_chk("R11 reloaded word", 12'h0F3 >> (W-1-b));
    ext_pulse_chk("R11 reloaded end", 1'b0);

    // R11: convert command aborts an external transfer
    cur_word_i = 12'hFFF;
    ext_start(1'b0);
    for (int b = 0; b < 3; b++) ext_pulse_chk("R11 before abort", 1'b1);
    @(negedge clk); rc_i = 1'b0;
    @(negedge clk);
    chk("R11 abort low", int'(sdata_o), 0);
    for (int b = 0; b < 3; b++) ext_pulse_chk("R11 R12 after abort", 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule